// File: doc/BRIEF.md
# Shared Atomic Counter with Two Master Ports

This block is a memory-mapped peripheral that holds one counter shared by two bus masters, typically two processors. A master never has to fetch the value, change it and store it back under a lock. It issues one write to the offset that names the operation it wants: increment, decrement, add the write data, or load the write data. The peripheral performs the whole read-modify-write on a single clock edge, so each update is atomic.

Each master port has its own request, address, data and wait-request signals. A two-way round-robin arbiter decides which port is served when both request in the same cycle. The other port is held off with wait-request and is served on the next cycle. Reads return the current count one cycle after they are accepted.

Top module: `shared_tally`

## Requirements
- R1: An accepted write whose address bits [3:2] equal 0 (byte offset 0) adds one to the counter on that clock edge; the write data and address bits [1:0] have no effect.
- R2: An accepted write whose address bits [3:2] equal 1 (byte offset 4) subtracts one from the counter; the write data has no effect.
- R3: An accepted write whose address bits [3:2] equal 2 (byte offset 8) replaces the counter with the counter plus the write data.
- R4: An accepted write whose address bits [3:2] equal 3 (byte offset 12) loads the write data into the counter.
- R5: All counter arithmetic wraps modulo 2^32: decrementing 0 gives 0xFFFFFFFF, and incrementing 0xFFFFFFFF gives 0.
- R6: An accepted read at any offset leaves the counter unchanged. It returns the count from the acceptance cycle on that port's read data, with that port's read-valid high for exactly the following cycle.
- R7: At most one request is accepted per cycle. A requesting port sees wait-request low exactly when it is granted, and a port that is not requesting sees wait-request low.
- R8: When both ports request at once, the port holding priority wins. After any grant, priority passes to the other port. Reset gives priority to port 0.
- R9: A port that loses arbitration and keeps requesting is granted on the next cycle, so it waits exactly one cycle.
- R10: No update is lost: after any mix of simultaneous and interleaved increments, decrements and adds from both ports, the count equals the modular sum of all of them.
- R11: While rst_n is low at a rising clock edge, the counter clears to zero and both read-valid outputs clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| p0_write | input | 1 | Port 0 write request |
| p0_read | input | 1 | Port 0 read request |
| p0_addr | input | 4 | Port 0 byte address; bits [3:2] select the operation |
| p0_wdata | input | 32 | Port 0 write data |
| p0_waitreq | output | 1 | Port 0 must hold its request |
| p0_rdata | output | 32 | Port 0 read data |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p1_write | input | 1 | Port 1 write request |
| p1_read | input | 1 | Port 1 read request |
| p1_addr | input | 4 | Port 1 byte address; bits [3:2] select the operation |
| p1_wdata | input | 32 | Port 1 write data |
| p1_waitreq | output | 1 | Port 1 must hold its request |
| p1_rdata | output | 32 | Port 1 read data |
| p1_rvalid | output | 1 | Port 1 read data valid |

## Verification
Assertions check the following on every cycle: the one-request-per-cycle grant, that only requesters are granted, that a contention loser is served next, that each write operation moves the counter by the right amount, and that idle cycles and reads leave the count unchanged. Only the bench's scenarios can show the full picture. These cover wrap-around at both ends, the round-robin order after reset and after a lone grant, the one-cycle read latency, and that a long mix of random simultaneous updates from both ports adds up exactly to the reference sum.

// File: rtl/tally_pkg.sv
// Shared definitions for the shared counter peripheral.
// Assumes the operation is selected by the 32-bit word index of the byte address.
package tally_pkg;

    typedef enum logic [1:0] {
        OP_INC  = 2'd0,
        OP_DEC  = 2'd1,
        OP_ADD  = 2'd2,
        OP_LOAD = 2'd3
    } tally_op_e;

    localparam int WORD_LSB = 2;

endpackage

// File: rtl/tally_rr_arb.sv
// Two-way round-robin arbiter.
// Grants at most one requester per cycle. On contention the port named by the
// priority pointer wins. After any grant the pointer moves to the other port.
// Assumes requests stay asserted until granted.
module tally_rr_arb #(
    parameter int NPORT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] req_i,
    output logic [NPORT-1:0] gnt_o
);

    localparam logic [NPORT-1:0] ALL_REQ = '1;

    logic prio_q;   // 0: port 0 preferred, 1: port 1 preferred

    // Grant decode: a lone requester wins, a tie goes to the priority holder.
    always_comb begin
        if (req_i == ALL_REQ) begin
            gnt_o = prio_q ? 2'b10 : 2'b01;
        end else begin
            gnt_o = req_i;
        end
    end

    // Priority pointer: hand priority to the port that was not just served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= 1'b0;
        end else if (|gnt_o) begin
            prio_q <= gnt_o[0];
        end
    end

    p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    p_grant_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~req_i) == '0);

    p_loser0_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == ALL_REQ && gnt_o[1]) |=> (!req_i[0] || gnt_o[0]));

    p_loser1_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == ALL_REQ && gnt_o[0]) |=> (!req_i[1] || gnt_o[1]));

endmodule

// File: rtl/tally_core.sv
// Counter register with operation decode.
// Performs one granted access per cycle: an update selected by the word
// index, or a registered read of the current count.
// Assumes wr_en and rd_en are never high together.
module tally_core
    import tally_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rd_done_o
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    tally_op_e         op;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] cnt_nxt;

    assign op = tally_op_e'(addr[WORD_LSB+1:WORD_LSB]);

    // Next-value decode for the selected write operation (wraps naturally).
    always_comb begin
        unique case (op)
            OP_INC:  cnt_nxt = cnt_q + ONE;
            OP_DEC:  cnt_nxt = cnt_q - ONE;
            OP_ADD:  cnt_nxt = cnt_q + wdata;
            default: cnt_nxt = wdata;
        endcase
    end

    // Counter register: single-edge read-modify-write on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= cnt_nxt;
        end
    end

    // Read path: capture the count and flag completion one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o   <= '0;
            rd_done_o <= 1'b0;
        end else begin
            rd_done_o <= rd_en;
            if (rd_en) begin
                rdata_o <= cnt_q;
            end
        end
    end

    p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_INC) |=> cnt_q == $past(cnt_q) + ONE);

    p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_DEC) |=> cnt_q == $past(cnt_q) - ONE);

    p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_ADD) |=> cnt_q == $past(cnt_q) + $past(wdata));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_LOAD) |=> cnt_q == $past(wdata));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cnt_q));

    p_read_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_done_o && rdata_o == $past(cnt_q)));

endmodule

// File: rtl/shared_tally.sv
// Shared atomic counter peripheral with two master ports.
// Arbitrates the two ports round-robin, steers the granted access into the
// counter core and routes read-valid back to the port that asked.
// Assumes each master raises at most one of write/read and holds it while
// its wait-request is high.
module shared_tally #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_write,
    input  logic              p0_read,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic              p0_waitreq,
    output logic [DATA_W-1:0] p0_rdata,
    output logic              p0_rvalid,
    input  logic              p1_write,
    input  logic              p1_read,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic              p1_waitreq,
    output logic [DATA_W-1:0] p1_rdata,
    output logic              p1_rvalid
);

    localparam int NPORT = 2;

    logic [NPORT-1:0]  req;
    logic [NPORT-1:0]  gnt;
    logic [NPORT-1:0]  rd_req;
    logic [NPORT-1:0]  wr_req;
    logic [NPORT-1:0]  rvalid_q;
    logic              core_wr;
    logic              core_rd;
    logic [ADDR_W-1:0] core_addr;
    logic [DATA_W-1:0] core_wdata;
    logic [DATA_W-1:0] core_rdata;
    logic              core_rd_done;

    assign wr_req = {p1_write, p0_write};
    assign rd_req = {p1_read, p0_read};
    assign req    = wr_req | rd_req;

    tally_rr_arb #(.NPORT(NPORT)) i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .gnt_o (gnt)
    );

    // Hold off every requester that was not granted this cycle.
    assign p0_waitreq = req[0] & ~gnt[0];
    assign p1_waitreq = req[1] & ~gnt[1];

    // Steer the granted port's access into the core.
    always_comb begin
        core_wr    = |(gnt & wr_req);
        core_rd    = |(gnt & rd_req);
        core_addr  = gnt[1] ? p1_addr  : p0_addr;
        core_wdata = gnt[1] ? p1_wdata : p0_wdata;
    end

    tally_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (core_wr),
        .rd_en     (core_rd),
        .addr      (core_addr),
        .wdata     (core_wdata),
        .rdata_o   (core_rdata),
        .rd_done_o (core_rd_done)
    );

    // Remember which port's read was accepted, to return its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= '0;
        end else begin
            rvalid_q <= gnt & rd_req;
        end
    end

    assign p0_rvalid = rvalid_q[0];
    assign p1_rvalid = rvalid_q[1];
    assign p0_rdata  = core_rdata;
    assign p1_rdata  = core_rdata;

    p_rvalid_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rvalid_q) == core_rd_done);

    p_served_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_waitreq && p1_waitreq));

endmodule

// File: tb/test_shared_tally.sv
// Bench for shared_tally: directed corner cases plus seeded random traffic
// from both ports, checked against a sum kept by the bench.
module test_shared_tally;

    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NRAND = 300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr [2];
    logic          rd [2];
    logic [AW-1:0] ad [2];
    logic [DW-1:0] wd [2];
    logic          wq [2];
    logic [DW-1:0] rdat [2];
    logic          rv [2];

    int checks = 0;
    int errors = 0;
    int wait_viol = 0;
    logic [DW-1:0] exp_sum;

    always #4 clk = ~clk;

    shared_tally #(.DATA_W(DW), .ADDR_W(AW)) i_shared_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .p0_write   (wr[0]),
        .p0_read    (rd[0]),
        .p0_addr    (ad[0]),
        .p0_wdata   (wd[0]),
        .p0_waitreq (wq[0]),
        .p0_rdata   (rdat[0]),
        .p0_rvalid  (rv[0]),
        .p1_write   (wr[1]),
        .p1_read    (rd[1]),
        .p1_addr    (ad[1]),
        .p1_wdata   (wd[1]),
        .p1_waitreq (wq[1]),
        .p1_rdata   (rdat[1]),
        .p1_rvalid  (rv[1])
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected effect of a write on the bench's sum.
    function automatic logic [DW-1:0] apply_op(input logic [DW-1:0] cur,
                                               input logic [AW-1:0] a,
                                               input logic [DW-1:0] d);
        case (a[3:2])
            2'd0:    return cur + 1;
            2'd1:    return cur - 1;
            2'd2:    return cur + d;
            default: return d;
        endcase
    endfunction

    // One access on port p; returns cycles spent waiting and read data.
    task automatic access(input int p, input logic is_rd, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output int waits,
                          output logic [DW-1:0] rval);
        @(negedge clk);
        wr[p] = ~is_rd;
        rd[p] = is_rd;
        ad[p] = a;
        wd[p] = d;
        #1;
        waits = 0;
        while (wq[p]) begin
            @(negedge clk);
            #1;
            waits++;
        end
        @(negedge clk);
        rval = rdat[p];
        if (is_rd && rv[p] !== 1'b1) begin
            errors++;
            checks++;
            $display("FAIL R6 rvalid actual=%b expected=1", rv[p]);
        end
        wr[p] = 1'b0;
        rd[p] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rand_port(input int p);
        int w;
        logic [DW-1:0] dummy;
        for (int i = 0; i < NRAND; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'((($urandom % 3) << 2) | ($urandom % 4));
            d = $urandom;
            access(p, 1'b0, a, d, w, dummy);
            exp_sum = apply_op(exp_sum, a, d);
            if (w > 1) wait_viol++;
            for (int g = 0; g < int'($urandom % 3); g++) @(negedge clk);
        end
    endtask

    initial begin
        int w0, w1;
        logic [DW-1:0] v, v2;
        for (int p = 0; p < 2; p++) begin
            wr[p] = 0; rd[p] = 0; ad[p] = '0; wd[p] = '0;
        end
        void'($urandom(32'd20240611));
        do_reset();

        // Reset state
        #1;
        chk("R7 idle waitreq", {31'd0, wq[0] | wq[1]}, 32'd0);
        chk("R11 rvalid clear", {31'd0, rv[0] | rv[1]}, 32'd0);
        access(0, 1'b1, 4'h0, '0, w0, v);
        chk("R11 count after reset", v, 32'd0);

        // Each operation, data ignored where required
        access(0, 1'b0, 4'h3, 32'hDEADBEEF, w0, v);
        access(1, 1'b1, 4'h0, '0, w1, v);
        chk("R1 increment", v, 32'd1);
        access(1, 1'b0, 4'h4, 32'h55, w1, v);
        access(0, 1'b1, 4'h8, '0, w0, v);
        chk("R2 decrement", v, 32'd0);
        access(0, 1'b0, 4'h4, 32'h1234, w0, v);
        access(0, 1'b1, 4'h0, '0, w0, v);
        chk("R5 wrap below zero", v, 32'hFFFFFFFF);
        access(1, 1'b0, 4'h0, '0, w1, v);
        access(1, 1'b1, 4'h0, '0, w1, v);
        chk("R5 wrap above max", v, 32'd0);
        access(0, 1'b0, 4'hC, 32'h7FFFFFF0, w0, v);
        access(0, 1'b1, 4'h4, '0, w0, v);
        chk("R4 load", v, 32'h7FFFFFF0);
        access(1, 1'b0, 4'h8, 32'h20, w1, v);
        access(1, 1'b1, 4'h0, '0, w1, v);
        chk("R3 add", v, 32'h80000010);
        access(0, 1'b0, 4'hA, 32'hFFFFFFFF, w0, v);
        access(0, 1'b1, 4'hD, '0, w0, v);
        access(1, 1'b1, 4'h6, '0, w1, v2);
        chk("R3 add wraps", v, 32'h8000000F);
        chk("R6 read leaves count", v2, 32'h8000000F);

        // Arbitration order after reset
        do_reset();
        fork
            access(0, 1'b0, 4'h0, '0, w0, v);
            access(1, 1'b0, 4'h0, '0, w1, v2);
        join
        chk("R8 port0 wins after reset", w0, 0);
        chk("R9 port1 waits one", w1, 1);
        access(0, 1'b0, 4'h0, '0, w0, v);
        fork
            access(0, 1'b0, 4'h0, '0, w0, v);
            access(1, 1'b0, 4'h0, '0, w1, v2);
        join
        chk("R8 port1 holds priority", w1, 0);
        chk("R9 port0 waits one", w0, 1);
        access(1, 1'b1, 4'h0, '0, w1, v);
        chk("R11 reset cleared count", v, 32'd5);

        // Simultaneous read and write: read sees pre-update value
        fork
            access(0, 1'b1, 4'h0, '0, w0, v);
            access(1, 1'b0, 4'h8, 32'd10, w1, v2);
        join
        chk("R6 read before queued write", v, 32'd5);
        access(0, 1'b1, 4'h0, '0, w0, v);
        chk("R7 one access per cycle", v, 32'd15);

        // Random interleaved and simultaneous updates
        exp_sum = 32'd15;
        fork
            rand_port(0);
            rand_port(1);
        join
        access(0, 1'b1, 4'h0, '0, w0, v);
        chk("R10 no lost updates", v, exp_sum);
        chk("R9 wait never exceeds one", wait_viol, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule